// File: doc/BRIEF.md
# Serialized Tag-Then-Data Cache Lookup

This block is the lookup path of a four-way set-associative cache that saves power. It looks at all four tag ways in one cycle. It activates a data array only in the following cycle, and then only the way whose tag matched. On a miss no data array is enabled at all, and the three ways that did not match stay idle on a hit.

A single request port carries reads, writes and line fills. After a request is accepted the port stays busy until the response is presented, so at most one request is in flight. A read hit returns one 144-bit slice of the 64-byte line. A write hit stores one slice. A miss is reported after the tag cycle alone.

A fill request handles allocation. When the line is absent, the fill places the tag into the way that the set's pseudo-LRU state names as the victim. Fetching the line from the next level and any coherence handling happen outside this block. The per-way data enables are outputs, so the power domains of the data arrays can follow them.

Top module: `ser_cache_lookup`

## Requirements
- R1: After `rst_ni` is released, `req_ready_o` is 1, and `resp_valid_o`, `resp_hit_o`, `resp_miss_o` and `data_en_o` are 0. Every line is invalid, so the first lookup to any address misses.
- R2: `data_en_o` is either zero or one-hot, and bit w enables data way w. It is zero in the tag cycle (the cycle after acceptance) and throughout the handling of any miss or fill.
- R3: For a read that hits, `data_en_o` selects the hit way in the second cycle after acceptance. Two cycles after acceptance, `resp_valid_o` and `resp_hit_o` are 1, and `resp_rdata_o` carries the slice at index addr[5:4] of that way.
- R4: For a read or write that misses, `resp_valid_o` and `resp_miss_o` are 1 one cycle after acceptance, and no data way is enabled for that request.
- R5: `req_ready_o` is 0 from the cycle after acceptance until the cycle in which that request's response is presented, and it is 1 in that cycle.
- R6: A write that hits stores `req_wdata_i` into slice addr[5:4] of the hit way during its data cycle, and it responds with a hit two cycles after acceptance. A write that misses changes no stored tag, valid bit or data.
- R7: A fill request (`req_fill_i` = 1) responds one cycle after acceptance and has no data phase. If the line is absent, the fill writes the tag into the pseudo-LRU victim way, marks the line valid and reports a miss. If the line is present, the fill reports a hit and changes nothing.
- R8: Each set holds three pseudo-LRU bits (root, left, right), all reset to 0. To choose the victim, a root of 0 picks between ways 0 and 1 using the left bit (0 means way 0). A root of 1 picks between ways 2 and 3 using the right bit (0 means way 2). A read hit, a write hit or an install to way w points the root away from w's pair and points the pair's bit away from w. From reset, four fills of distinct tags to one set land in ways 0, 2, 1 and 3.
- R9: The address splits into offset addr[5:0], set addr[9:6] and a 30-bit tag addr[39:10]. Tags, valid bits and pseudo-LRU state are kept separately for each set.
- R10: Each accepted request produces exactly one response. The response is a one-cycle `resp_valid_o` pulse in which exactly one of `resp_hit_o` and `resp_miss_o` is 1. Both flags are 0 whenever `resp_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Port can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_fill_i | input | 1 | Line fill request (takes priority over `req_we_i`) |
| req_addr_i | input | 40 | Byte address |
| req_wdata_i | input | 144 | Write slice |
| resp_valid_o | output | 1 | Response pulse |
| resp_hit_o | output | 1 | Lookup hit |
| resp_miss_o | output | 1 | Lookup miss |
| resp_rdata_o | output | 144 | Read slice, meaningful on a read-hit response |
| data_en_o | output | 4 | Per-way data-array enable |

## Verification
Each result has a fixed cycle, counted from the accepting clock edge. `req_ready_o` falls one edge after acceptance. A miss or fill response arrives after one edge. A hit has its data enable after one edge and its response after two, and `req_ready_o` returns in the cycle of the response. The bench drives each request at a falling edge and then compares every output at each following falling edge against a behavioural model. It never skips a cycle, so a response that is early or late, or an enable that is extra or missing, shows up in the cycle where it appears. The model follows the tree rule of R8 to predict which way each fill selects, and the one-hot `data_en_o` on later hits shows where the line was placed.

// File: rtl/ser_cache_pkg.sv
package ser_cache_pkg;
  localparam int unsigned WAYS  = 4;
  localparam int unsigned WAY_W = 2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TAG  = 2'd1,
    ST_DATA = 2'd2
  } lookup_st_e;
endpackage

// File: rtl/ser_tag_store.sv
module ser_tag_store
  import ser_cache_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  parameter int unsigned TAG_W    = 30,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic [WAYS-1:0]  hit_vec_o,
  input  logic             ins_i,
  input  logic [WAY_W-1:0] ins_way_i
);
  logic [TAG_W-1:0] tag_q   [NUM_SETS][WAYS];
  logic [WAYS-1:0]  valid_q [NUM_SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) valid_q[s] <= '0;
    end else if (ins_i) begin
      valid_q[set_i][ins_way_i] <= 1'b1;
    end
  end

  // tag bits carry no reset; valid gates them
  always_ff @(posedge clk_i) begin
    if (ins_i) tag_q[set_i][ins_way_i] <= tag_i;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec_o[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
  end
endmodule

// File: rtl/ser_plru.sv
module ser_plru
  import ser_cache_pkg::*;
#(
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned SET_W   = $clog2(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             upd_i,
  input  logic [WAY_W-1:0] upd_way_i,
  output logic [WAY_W-1:0] victim_o
);
  // bit 0 root, bit 1 pair {0,1}, bit 2 pair {2,3}
  logic [2:0] tree_q [NUM_SETS];
  logic [2:0] cur;
  logic [2:0] nxt;

  assign cur = tree_q[set_i];

  always_comb begin
    victim_o = cur[0] ? {1'b1, cur[2]} : {1'b0, cur[1]};
  end

  always_comb begin
    nxt = cur;
    if (upd_way_i[1]) begin
      nxt[0] = 1'b0;
      nxt[2] = ~upd_way_i[0];
    end else begin
      nxt[0] = 1'b1;
      nxt[1] = ~upd_way_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
    end else if (upd_i) begin
      tree_q[set_i] <= nxt;
    end
  end
endmodule

// File: rtl/ser_data_way.sv
module ser_data_way #(
  parameter int unsigned DEPTH  = 64,
  parameter int unsigned DATA_W = 144,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_o <= '0;
    end else if (en_i) begin
      if (we_i) mem_q[idx_i] <= wdata_i;
      else      rdata_o      <= mem_q[idx_i];
    end
  end
endmodule

// File: rtl/ser_cache_lookup.sv
module ser_cache_lookup
  import ser_cache_pkg::*;
#(
  parameter int unsigned NUM_SETS   = 16,
  parameter int unsigned TAG_W      = 30,
  parameter int unsigned LINE_BYTES = 64,
  parameter int unsigned BEAT_BYTES = 16,
  parameter int unsigned DATA_W     = 144,
  parameter int unsigned ADDR_W     = TAG_W + $clog2(NUM_SETS) + $clog2(LINE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic              req_fill_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic              resp_miss_o,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic [WAYS-1:0]   data_en_o
);
  localparam int unsigned SET_W   = $clog2(NUM_SETS);
  localparam int unsigned OFF_W   = $clog2(LINE_BYTES);
  localparam int unsigned SLICES  = LINE_BYTES / BEAT_BYTES;
  localparam int unsigned SLICE_W = $clog2(SLICES);
  localparam int unsigned DEPTH   = NUM_SETS * SLICES;
  localparam int unsigned IDX_W   = $clog2(DEPTH);

  lookup_st_e        state_q;
  logic              we_q, fill_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [WAY_W-1:0]  way_q;
  logic              rvalid_q, rhit_q, rmiss_q;

  logic [SET_W-1:0]   set_idx;
  logic [TAG_W-1:0]   tag_val;
  logic [SLICE_W-1:0] slice_idx;
  logic [IDX_W-1:0]   arr_idx;
  logic [WAYS-1:0]    hit_vec;
  logic               tag_hit;
  logic [WAY_W-1:0]   hit_way;
  logic [WAY_W-1:0]   victim;
  logic               ins;
  logic               lru_upd;
  logic [WAY_W-1:0]   lru_way;
  logic [DATA_W-1:0]  way_rdata [WAYS];

  assign set_idx   = addr_q[OFF_W +: SET_W];
  assign tag_val   = addr_q[OFF_W + SET_W +: TAG_W];
  assign slice_idx = addr_q[OFF_W-1 -: SLICE_W];
  assign arr_idx   = {set_idx, slice_idx};

  assign tag_hit = |hit_vec;
  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) if (hit_vec[w]) hit_way = WAY_W'(w);
  end

  // install only for a fill whose line is absent
  assign ins     = (state_q == ST_TAG) && fill_q && !tag_hit;
  assign lru_upd = (state_q == ST_TAG) && (ins || (tag_hit && !fill_q));
  assign lru_way = ins ? victim : hit_way;

  ser_tag_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) tags_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_idx),
    .tag_i     (tag_val),
    .hit_vec_o (hit_vec),
    .ins_i     (ins),
    .ins_way_i (victim)
  );

  ser_plru #(.NUM_SETS(NUM_SETS)) lru_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (set_idx),
    .upd_i     (lru_upd),
    .upd_way_i (lru_way),
    .victim_o  (victim)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign data_en_o[w] = (state_q == ST_DATA) && (way_q == WAY_W'(w));
    ser_data_way #(.DEPTH(DEPTH), .DATA_W(DATA_W)) arr_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (data_en_o[w]),
      .we_i    (we_q),
      .idx_i   (arr_idx),
      .wdata_i (wdata_q),
      .rdata_o (way_rdata[w])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      we_q     <= 1'b0;
      fill_q   <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      way_q    <= '0;
      rvalid_q <= 1'b0;
      rhit_q   <= 1'b0;
      rmiss_q  <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      rhit_q   <= 1'b0;
      rmiss_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            we_q    <= req_we_i;
            fill_q  <= req_fill_i;
            addr_q  <= req_addr_i;
            wdata_q <= req_wdata_i;
            state_q <= ST_TAG;
          end
        end
        ST_TAG: begin
          if (tag_hit && !fill_q) begin
            way_q   <= hit_way;
            state_q <= ST_DATA;
          end else begin
            rvalid_q <= 1'b1;
            rhit_q   <= tag_hit;
            rmiss_q  <= !tag_hit;
            state_q  <= ST_IDLE;
          end
        end
        ST_DATA: begin
          rvalid_q <= 1'b1;
          rhit_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_valid_o = rvalid_q;
  assign resp_hit_o   = rhit_q;
  assign resp_miss_o  = rmiss_q;
  assign resp_rdata_o = way_rdata[way_q];
endmodule

// File: rtl/ser_cache_lookup_chk.sv
module ser_cache_lookup_chk
  import ser_cache_pkg::*;
(
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic            resp_valid_o,
  input logic            resp_hit_o,
  input logic            resp_miss_o,
  input logic [WAYS-1:0] data_en_o
);
  logic accept;
  assign accept = req_valid_i && req_ready_o;

  p_en_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(data_en_o));

  p_tag_cycle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (data_en_o == '0));

  p_en_then_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_en_o != '0) |=> (resp_valid_o && resp_hit_o));

  p_miss_no_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_miss_o |-> (data_en_o == '0));

  p_busy_after_accept_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);

  p_ready_with_resp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> req_ready_o);

  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (resp_hit_o ^ resp_miss_o));

  p_flags_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> (!resp_hit_o && !resp_miss_o));

  p_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
endmodule

bind ser_cache_lookup ser_cache_lookup_chk chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .resp_valid_o (resp_valid_o),
  .resp_hit_o   (resp_hit_o),
  .resp_miss_o  (resp_miss_o),
  .data_en_o    (data_en_o)
);

// File: tb/ser_cache_lookup_tb_top.sv
`timescale 1ns/1ps
module ser_cache_lookup_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_we = 1'b0;
  logic         req_fill = 1'b0;
  logic [39:0]  req_addr = '0;
  logic [143:0] req_wdata = '0;
  logic         req_ready, resp_valid, resp_hit, resp_miss;
  logic [143:0] resp_rdata;
  logic [3:0]   data_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ser_cache_lookup dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_fill_i(req_fill),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_miss_o(resp_miss),
    .resp_rdata_o(resp_rdata), .data_en_o(data_en)
  );

  // behavioural model
  logic [29:0]  m_tag  [16][4];
  bit           m_val  [16][4];
  bit   [2:0]   m_tree [16];
  logic [143:0] m_data [16][4][4];

  function automatic int m_find(int s, logic [29:0] t);
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction

  function automatic int m_victim(int s);
    if (m_tree[s][0] == 1'b0) return m_tree[s][1] ? 1 : 0;
    return m_tree[s][2] ? 3 : 2;
  endfunction

  function automatic void m_touch(int s, int w);
    if (w < 2) begin m_tree[s][0] = 1'b1; m_tree[s][1] = (w == 0); end
    else       begin m_tree[s][0] = 1'b0; m_tree[s][2] = (w == 2); end
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [143:0] act, logic [143:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic idle_outputs(string rq);
    chk(resp_valid == 1'b0, rq, "resp_valid", 144'(resp_valid), 0);
    chk(resp_hit == 1'b0 && resp_miss == 1'b0, rq, "flags",
        144'({resp_hit, resp_miss}), 0);
    chk(data_en == 4'b0, rq, "data_en", 144'(data_en), 0);
  endtask

  // kind: 0 read, 1 write, 2 fill
  task automatic do_op(int kind, logic [29:0] tag, int s, int sl, logic [143:0] wd, string rq);
    int way;
    @(negedge clk);
    chk(req_ready == 1'b1, "R5", "ready before request", 144'(req_ready), 1);
    way = m_find(s, tag);
    req_valid = 1'b1;
    req_we    = (kind == 1);
    req_fill  = (kind == 2);
    req_addr  = {tag, 4'(s), 2'(sl), 4'h0};
    req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // tag cycle
    chk(req_ready == 1'b0, "R5", "ready in tag cycle", 144'(req_ready), 0);
    idle_outputs("R2");
    @(negedge clk);
    if (kind == 2 || way < 0) begin
      chk(resp_valid == 1'b1, rq, "resp_valid after tag", 144'(resp_valid), 1);
      chk(resp_hit == (way >= 0) && resp_miss == (way < 0), rq, "hit/miss",
          144'({resp_hit, resp_miss}), 144'({way >= 0, way < 0}));
      chk(data_en == 4'b0, "R4", "no data enable", 144'(data_en), 0);
      chk(req_ready == 1'b1, "R5", "ready with resp", 144'(req_ready), 1);
      if (kind == 2 && way < 0) begin
        int v = m_victim(s);
        m_tag[s][v] = tag;
        m_val[s][v] = 1'b1;
        m_touch(s, v);
      end
    end else begin
      chk(resp_valid == 1'b0, rq, "no resp in data cycle", 144'(resp_valid), 0);
      chk(data_en == 4'(1 << way), rq, "data_en hit way", 144'(data_en), 144'(1 << way));
      chk(req_ready == 1'b0, "R5", "ready in data cycle", 144'(req_ready), 0);
      m_touch(s, way);
      @(negedge clk);
      chk(resp_valid && resp_hit && !resp_miss, rq, "hit resp",
          144'({resp_valid, resp_hit, resp_miss}), 144'(3'b110));
      chk(req_ready == 1'b1, "R5", "ready with hit resp", 144'(req_ready), 1);
      chk(data_en == 4'b0, "R2", "enable dropped", 144'(data_en), 0);
      if (kind == 0) chk(resp_rdata == m_data[s][way][sl], rq, "rdata",
                         resp_rdata, m_data[s][way][sl]);
      else m_data[s][way][sl] = wd;
    end
    @(negedge clk);
    idle_outputs("R10");
  endtask

  task automatic run_all();
    logic [159:0] r;
    for (int s = 0; s < 16; s++) begin
      m_tree[s] = '0;
      for (int w = 0; w < 4; w++) begin
        m_val[s][w] = 1'b0;
        m_tag[s][w] = '0;
        for (int k = 0; k < 4; k++) m_data[s][w][k] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", 144'(req_ready), 1);
    idle_outputs("R1");

    do_op(0, 30'h0A5A5, 3, 0, '0, "R1");         // cold read misses
    do_op(2, 30'h0A5A5, 3, 0, '0, "R7");         // fill -> way 0
    do_op(2, 30'h0A5A5, 3, 0, '0, "R7");         // fill of present line: hit
    do_op(1, 30'h0A5A5, 3, 2, 144'hC0FFEE_1234, "R6");
    do_op(0, 30'h0A5A5, 3, 2, '0, "R3");
    do_op(2, 30'h00B01, 3, 0, '0, "R8");         // way 2
    do_op(2, 30'h00C02, 3, 0, '0, "R8");         // way 1
    do_op(2, 30'h00D03, 3, 0, '0, "R8");         // way 3
    do_op(1, 30'h00B01, 3, 1, 144'hBEEF, "R8");
    do_op(1, 30'h00D03, 3, 3, 144'hD00D, "R6");
    do_op(0, 30'h00B01, 3, 1, '0, "R3");
    do_op(1, 30'h3FFFF, 3, 1, 144'hBAD, "R4");   // write miss
    do_op(0, 30'h00B01, 3, 1, '0, "R6");         // unchanged after write miss
    do_op(0, 30'h3FFFF, 3, 1, '0, "R6");         // still absent
    do_op(2, 30'h00E04, 3, 0, '0, "R8");         // eviction by tree
    do_op(0, 30'h0A5A5, 3, 2, '0, "R8");
    do_op(0, 30'h00B01, 5, 1, '0, "R9");         // other set: absent
    do_op(2, 30'h00B01, 5, 1, '0, "R9");         // own tree -> way 0
    do_op(1, 30'h00B01, 5, 1, 144'h55, "R9");
    do_op(0, 30'h00B01, 5, 1, '0, "R9");

    for (int i = 0; i < 300; i++) begin
      r = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
      do_op(int'($urandom_range(0, 2)), 30'($urandom_range(1, 6)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
            r[143:0], "R10");
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule